// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is a position and event counter. It counts either on every clock cycle of the system clock or from two quadrature inputs, A and B, that come from a rotary or linear encoder. A mode field selects the counting source. Mode 0 counts up on the internal clock. Mode 1 decodes at twice the line rate on A edges, with B giving the direction. Mode 2 does the same on B edges, with A giving the direction. Mode 3 decodes at four times the line rate on every edge of both inputs. The count runs between zero and a programmable ceiling and wraps at either end. A flag records the direction of the last step.

A small register bus gives software access to the block. Software can start and stop counting, load the count, set the ceiling and pick the mode. The ceiling can be written straight into the active copy. It can also be staged in a shadow copy and moved into the active copy by a software update event.

The two encoder inputs first pass through a two-stage synchroniser. They then go to a phase state machine with four states, named after the sampled {A,B} pair: PH_00, PH_10, PH_11 and PH_01. On every clock the machine takes one of four transitions. FWD moves one state along the cycle PH_00→PH_10→PH_11→PH_01→PH_00. REV moves one state the other way. DOUBLE changes both bits at once and is illegal. HOLD leaves the pair unchanged. The selected mode decides which FWD and REV transitions become count steps.

Top module: `qenc_counter`

## Requirements
- R1: After reset, the control register, the mode register, the count and the direction flag are all 0, and the ceiling (both shadow and active) is all ones.
- R2: In mode 0 with the run bit (control bit 0) set to 1, the count rises by one on every clock. With the run bit at 0, the count holds its value in every mode.
- R3: In mode 1, a change of A alone steps the count. The step is up when the new A differs from B and down when they are equal. A change of B alone does not step the count.
- R4: In mode 2, a change of B alone steps the count. The step is up when the new B equals A and down when they differ. A change of A alone does not step the count.
- R5: In mode 3, every single-bit change of {A,B} steps the count. A FWD transition counts up and a REV transition counts down. A DOUBLE transition gives no step in any encoder mode.
- R6: An up step taken at or above the active ceiling gives 0. A down step taken at 0, or while the count is above the ceiling, gives the active ceiling.
- R7: A bus write to the count (address 2) loads the written value when it is no greater than the active ceiling, and has priority over a step in the same cycle. A larger value is ignored.
- R8: The direction flag, seen on down_o and on control bit 2 (read-only), is 1 after a down step and 0 after an up step. It holds its value while no step is taken.
- R9: When control bit 1 (preload) is 0, a ceiling write (address 3) updates both the shadow and the active ceiling. When it is 1, only the shadow changes. Reads of address 3 return the shadow.
- R10: Writing 1 to bit 0 of the event register (address 4) copies the shadow ceiling into the active ceiling.
- R11: Mode values 4 to 7 freeze the count whatever the inputs do. Bus writes to the count still load it.
- R12: A change on A or B shows in the count at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 control, 1 mode, 2 count, 3 ceiling, 4 event |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for bus_addr (combinational) |
| enc_a | input | 1 | Quadrature input A (asynchronous) |
| enc_b | input | 1 | Quadrature input B (asynchronous) |
| count_o | output | CW | Current count |
| down_o | output | 1 | Direction of the last step, 1 = down |

## Verification
Register writes take effect at the rising edge that samples the strobe. Encoder edges reach the count at the third rising edge, after two synchroniser stages and the phase register. The bench drives every input on a falling edge and samples every output on a falling edge. Its reference model advances once per rising edge and uses only the input values from before that edge. The count and direction are compared with the model on every falling edge. The directed latency check looks at the count two and three falling edges after an input change, so that the exact cycle of the step is confirmed.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int AW = 3;

    localparam logic [AW-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [AW-1:0] ADDR_MODE  = 3'd1;
    localparam logic [AW-1:0] ADDR_COUNT = 3'd2;
    localparam logic [AW-1:0] ADDR_CEIL  = 3'd3;
    localparam logic [AW-1:0] ADDR_EVENT = 3'd4;

    // phase state of the sampled pair {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_10 = 2'b10,
        PH_11 = 2'b11,
        PH_01 = 2'b01
    } phase_e;

    typedef enum logic [2:0] {
        MD_CLOCK = 3'd0,
        MD_XA    = 3'd1,
        MD_XB    = 3'd2,
        MD_X4    = 3'd3
    } mode_e;

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [STAGES-1:0][N-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab_s,
    input  logic [2:0] mode,
    output logic       step_up,
    output logic       step_dn
);

    phase_e phase_q;
    phase_e ph_fwd;
    phase_e ph_rev;
    logic   a_chg, b_chg;

    // state register: follows the synchronised pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_00;
        else        phase_q <= phase_e'(ab_s);
    end

    // neighbour states of the current phase
    always_comb begin
        unique case (phase_q)
            PH_00: begin ph_fwd = PH_10; ph_rev = PH_01; end
            PH_10: begin ph_fwd = PH_11; ph_rev = PH_00; end
            PH_11: begin ph_fwd = PH_01; ph_rev = PH_10; end
            PH_01: begin ph_fwd = PH_00; ph_rev = PH_11; end
        endcase
    end

    assign a_chg = ab_s[1] ^ phase_q[1];
    assign b_chg = ab_s[0] ^ phase_q[0];

    // output process: turn transitions into steps per mode
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        case (mode)
            MD_CLOCK: step_up = 1'b1;
            MD_XA: if (a_chg && !b_chg) begin
                step_up = ab_s[1] ^ ab_s[0];
                step_dn = ~(ab_s[1] ^ ab_s[0]);
            end
            MD_XB: if (b_chg && !a_chg) begin
                step_up = ~(ab_s[1] ^ ab_s[0]);
                step_dn = ab_s[1] ^ ab_s[0];
            end
            MD_X4: if (a_chg ^ b_chg) begin
                step_up = (ab_s == ph_fwd);
                step_dn = (ab_s == ph_rev);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] ceil_act,
    output logic [W-1:0] count,
    output logic         down
);

    logic ld_ok;
    assign ld_ok = ld && (ld_val <= ceil_act);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            down  <= 1'b0;
        end else if (ld_ok) begin
            count <= ld_val;
        end else if (run && step_up) begin
            count <= (count >= ceil_act) ? '0 : count + 1'b1;
            down  <= 1'b0;
        end else if (run && step_dn) begin
            count <= (count == '0 || count > ceil_act) ? ceil_act : count - 1'b1;
            down  <= 1'b1;
        end
    end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CW = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    input  logic          enc_a,
    input  logic          enc_b,
    output logic [CW-1:0] count_o,
    output logic          down_o
);

    localparam logic [CW-1:0] CEIL_RST = '1;

    logic          run_q, pre_q;
    logic [2:0]    mode_q;
    logic [CW-1:0] ceil_pre_q, ceil_act_q;
    logic [1:0]    ab_s;
    logic          step_up, step_dn;
    logic          wr_ctrl, wr_mode, wr_cnt, wr_ceil, wr_evt;

    assign wr_ctrl = bus_wr && bus_addr == ADDR_CTRL;
    assign wr_mode = bus_wr && bus_addr == ADDR_MODE;
    assign wr_cnt  = bus_wr && bus_addr == ADDR_COUNT;
    assign wr_ceil = bus_wr && bus_addr == ADDR_CEIL;
    assign wr_evt  = bus_wr && bus_addr == ADDR_EVENT && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            pre_q      <= 1'b0;
            mode_q     <= '0;
            ceil_pre_q <= CEIL_RST;
            ceil_act_q <= CEIL_RST;
        end else begin
            if (wr_ctrl) begin
                run_q <= bus_wdata[0];
                pre_q <= bus_wdata[1];
            end
            if (wr_mode) mode_q <= bus_wdata[2:0];
            if (wr_ceil) begin
                ceil_pre_q <= bus_wdata;
                if (!pre_q) ceil_act_q <= bus_wdata;
            end
            if (wr_evt) ceil_act_q <= ceil_pre_q;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:  bus_rdata[2:0] = {down_o, pre_q, run_q};
            ADDR_MODE:  bus_rdata[2:0] = mode_q;
            ADDR_COUNT: bus_rdata = count_o;
            ADDR_CEIL:  bus_rdata = ceil_pre_q;
            default:    bus_rdata = '0;
        endcase
    end

    qenc_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_a, enc_b}),
        .dout (ab_s)
    );

    qenc_decoder u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .ab_s   (ab_s),
        .mode   (mode_q),
        .step_up(step_up),
        .step_dn(step_dn)
    );

    qenc_count #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .step_up (step_up),
        .step_dn (step_dn),
        .ld      (wr_cnt),
        .ld_val  (bus_wdata),
        .ceil_act(ceil_act_q),
        .count   (count_o),
        .down    (down_o)
    );

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [2:0]    bus_addr,
    input logic [CW-1:0] bus_wdata,
    input logic          run_q,
    input logic          pre_q,
    input logic [2:0]    mode_q,
    input logic [CW-1:0] ceil_act_q,
    input logic          step_up,
    input logic          step_dn,
    input logic [CW-1:0] count_o,
    input logic          down_o
);

    logic cnt_wr, ceil_wr;
    assign cnt_wr  = bus_wr && bus_addr == 3'd2;
    assign ceil_wr = bus_wr && bus_addr == 3'd3;

    a_r6_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && step_up && count_o == ceil_act_q && !cnt_wr) |=> count_o == '0);

    a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && step_dn && count_o == '0 && !cnt_wr) |=> count_o == $past(ceil_act_q));

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cnt_wr) |=> $stable(count_o));

    a_r11_frozen_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q >= 3'd4 && !cnt_wr) |=> $stable(count_o));

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |-> !step_dn);

    a_r8_down_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && step_dn && !cnt_wr) |=> down_o);

    a_r9_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_q && ceil_wr) |=> $stable(ceil_act_q));

    a_r7_ignore_big: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && bus_wdata > ceil_act_q && !(run_q && (step_up || step_dn)))
        |=> $stable(count_o));

endmodule

bind qenc_counter qenc_counter_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run_q     (run_q),
    .pre_q     (pre_q),
    .mode_q    (mode_q),
    .ceil_act_q(ceil_act_q),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .count_o   (count_o),
    .down_o    (down_o)
);

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;
    logic [15:0] count_o;
    logic        down_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qenc_counter #(.CW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_a(enc_a),
        .enc_b(enc_b), .count_o(count_o), .down_o(down_o)
    );

    // behavioural reference model
    int         m_cnt, m_ceil_act, m_ceil_pre, m_mode;
    bit         m_run, m_pre, m_dn;
    logic [1:0] m_s1, m_s2, m_ph;

    function automatic int gidx(input logic [1:0] ab);
        case (ab)
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ceil_act = 65535; m_ceil_pre = 65535; m_mode = 0;
            m_run = 0; m_pre = 0; m_dn = 0;
            m_s1 = 2'b00; m_s2 = 2'b00; m_ph = 2'b00;
        end else begin
            int  diff, dir;
            bit  achg, bchg;
            achg = m_s2[1] != m_ph[1];
            bchg = m_s2[0] != m_ph[0];
            diff = (gidx(m_s2) - gidx(m_ph) + 4) % 4;
            dir = 0;
            if (m_run) begin
                if (m_mode == 0) dir = 1;
                else if (m_mode == 1 && achg && !bchg) dir = (diff == 1) ? 1 : -1;
                else if (m_mode == 2 && bchg && !achg) dir = (diff == 1) ? 1 : -1;
                else if (m_mode == 3 && (achg != bchg)) dir = (diff == 1) ? 1 : -1;
            end
            if (bus_wr && bus_addr == 3'd2 && int'(bus_wdata) <= m_ceil_act)
                m_cnt = int'(bus_wdata);
            else if (dir == 1) begin
                m_cnt = (m_cnt >= m_ceil_act) ? 0 : m_cnt + 1; m_dn = 0;
            end else if (dir == -1) begin
                m_cnt = (m_cnt == 0 || m_cnt > m_ceil_act) ? m_ceil_act : m_cnt - 1; m_dn = 1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin m_run = bus_wdata[0]; m_pre = bus_wdata[1]; end
                    3'd1: m_mode = int'(bus_wdata[2:0]);
                    3'd3: begin
                        if (!m_pre) m_ceil_act = int'(bus_wdata);
                        m_ceil_pre = int'(bus_wdata);
                    end
                    3'd4: if (bus_wdata[0]) m_ceil_act = m_ceil_pre;
                    default: ;
                endcase
            end
            m_ph = m_s2; m_s2 = m_s1; m_s1 = {enc_a, enc_b};
        end
    end

    // compare with the model on every falling edge (R12 timing, R8 flag)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (int'(count_o) != m_cnt || down_o != m_dn) begin
                n_bad++;
                $display("FAIL R12 model: count_o=%0d down_o=%0d expected %0d %0d",
                         count_o, down_o, m_cnt, m_dn);
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    task automatic step_ab(input logic a, input logic b);
        @(negedge clk);
        enc_a = a; enc_b = b;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int v, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 0);
        rd(3'd1, v); check("R1 mode", v, 0);
        rd(3'd2, v); check("R1 count", v, 0);
        rd(3'd3, v); check("R1 ceiling", v, 65535);
        check("R1 down_o", int'(down_o), 0);

        // R2 clock counting and hold
        wr(3'd3, 16'd100);
        wr(3'd0, 16'd1);
        c0 = int'(count_o);
        repeat (5) @(negedge clk);
        check("R2 counts per clock", int'(count_o), c0 + 5);
        wr(3'd0, 16'd0);
        @(negedge clk);
        c0 = int'(count_o);
        repeat (4) @(negedge clk);
        check("R2 hold when stopped", int'(count_o), c0);

        // R12 latency, R5 x4 decoding
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd10);
        wr(3'd0, 16'd1);
        @(negedge clk);
        enc_a = 1'b1; enc_b = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 not yet after two edges", int'(count_o), 10);
        @(negedge clk);
        check("R12 step at third edge", int'(count_o), 11);
        step_ab(1, 1);
        step_ab(0, 1);
        step_ab(0, 0);
        check("R5 forward cycle", int'(count_o), 14);
        check("R8 up flag", int'(down_o), 0);
        step_ab(0, 1);
        step_ab(1, 1);
        check("R5 reverse", int'(count_o), 12);
        check("R8 down flag", int'(down_o), 1);
        rd(3'd0, v); check("R8 ctrl readback", v, 5);
        step_ab(0, 0);
        check("R5 double change no step", int'(count_o), 12);

        // R3 mode 1
        wr(3'd1, 16'd1);
        step_ab(0, 1);
        check("R3 B edge ignored", int'(count_o), 12);
        step_ab(1, 1);
        check("R3 A edge down", int'(count_o), 11);
        step_ab(0, 1);
        check("R3 A edge up", int'(count_o), 12);

        // R4 mode 2
        wr(3'd1, 16'd2);
        step_ab(1, 1);
        check("R4 A edge ignored", int'(count_o), 12);
        step_ab(1, 0);
        check("R4 B edge down", int'(count_o), 11);
        step_ab(1, 1);
        check("R4 B edge up", int'(count_o), 12);

        // R6 wrap
        wr(3'd0, 16'd0);
        wr(3'd3, 16'd20);
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd20);
        wr(3'd0, 16'd1);
        @(negedge clk);
        check("R6 up wrap to zero", int'(count_o), 0);
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'd1);
        step_ab(1, 0);
        check("R6 down wrap to ceiling", int'(count_o), 20);

        // R7 count load
        wr(3'd2, 16'd50);
        check("R7 above ceiling ignored", int'(count_o), 20);
        wr(3'd2, 16'd7);
        check("R7 load", int'(count_o), 7);

        // R9 / R10 preload
        wr(3'd0, 16'd2);
        wr(3'd3, 16'd5);
        rd(3'd3, v); check("R9 shadow readback", v, 5);
        wr(3'd2, 16'd15);
        check("R9 active unchanged", int'(count_o), 15);
        wr(3'd4, 16'd1);
        wr(3'd2, 16'd9);
        check("R10 event applied", int'(count_o), 15);
        wr(3'd2, 16'd4);
        check("R10 load under new ceiling", int'(count_o), 4);
        wr(3'd0, 16'd0);
        wr(3'd3, 16'd30);
        wr(3'd2, 16'd25);
        check("R9 immediate ceiling", int'(count_o), 25);

        // R11 frozen modes
        wr(3'd1, 16'd5);
        wr(3'd0, 16'd1);
        step_ab(0, 0);
        step_ab(1, 0);
        repeat (5) @(negedge clk);
        check("R11 frozen", int'(count_o), 25);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule